// File: doc/BRIEF.md
# Tape-Language Interpreter Core

This block runs programs written in the minimal eight-command tape language directly in hardware. A program of up to 64 three-bit opcodes is held in an on-chip program store, and it works on a tape of 32 byte-wide cells. Each clock cycle in run mode fetches and handles exactly one instruction. No jump table is built ahead of time. Each loop bracket is matched at run time by a signed depth counter. The counter walks the program counter forward or backward one slot per cycle until the partner bracket is found.

The block has two modes. With `run_mode` low, the program store is written one opcode per strobe and can be read back at any address. While in load mode the tape stays at zero, and the program counter, data pointer, depth counter and halt flag stay cleared. Raising `run_mode` starts execution at program address zero. Execution stops when a halt opcode is reached or when the program counter would leave the store. The result is then available in the output register, and any tape cell can be inspected through the display port.

Top module: `tape_interp`

## Requirements
- R1: While `rst_n` is low, the program store, tape, output register, program counter, data pointer and depth counter go to zero and `halted` goes low. This happens asynchronously.
- R2: When `run_mode`=0 and `prog_wr`=1, the edge stores `prog_op` at `prog_addr`. `prog_rdata` shows the opcode stored at `prog_addr` while `run_mode`=0 and reads 0 while `run_mode`=1. A write strobe in run mode leaves the store unchanged.
- R3: In run mode one instruction is handled per clock. The encodings are: 000 data pointer +1, 001 data pointer -1, 010 current cell +1, 011 current cell -1, 110 copy the current cell into `out_value`, 111 halt.
- R4: Cell arithmetic wraps modulo 256, so 0 minus 1 gives 255. The data pointer wraps modulo 32, so stepping back from cell 0 reaches cell 31.
- R5: Opcode 100 (loop open) raises the depth by one when the current cell is zero or the depth is already nonzero. While the depth is nonzero, no opcode other than the brackets has any effect, and that includes halt.
- R6: Opcode 101 (loop close) lowers the depth by one when the current cell is nonzero or the depth is already nonzero. Nested loops therefore pair correctly in both scan directions.
- R7: The program counter moves backward when the depth after this cycle's update is negative, and forward otherwise. A backward scan therefore resumes at the instruction right after the matching loop open.
- R8: Opcode 111 at depth zero holds the program counter and raises `halted`. `halted` then stays high until run mode is left.
- R9: Suppose a step would move the program counter below 0 or above 63. The instruction at the current address still takes effect, and then the block halts with the program counter held.
- R10: `clear`=1 zeroes every tape cell and `out_value` at the next edge, in either mode. In run mode no instruction is executed during that cycle, and the program counter, data pointer and depth hold.
- R11: While `run_mode`=0, the program counter, data pointer, depth and `halted` return to zero and the tape is zeroed. `out_value` keeps its value.
- R12: `disp_value` shows tape cell `disp_addr` when `disp_sel`=1 and `out_value` when `disp_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_mode | input | 1 | 1 = execute, 0 = load program |
| clear | input | 1 | Zero the tape and the output register |
| prog_wr | input | 1 | Program write strobe (load mode only) |
| prog_addr | input | 6 | Program store address for write and read-back |
| prog_op | input | 3 | Opcode to store |
| prog_rdata | output | 3 | Opcode at `prog_addr` in load mode, 0 in run mode |
| disp_sel | input | 1 | 1 = show a tape cell, 0 = show the output register |
| disp_addr | input | 5 | Tape cell to show |
| disp_value | output | 8 | Selected display value |
| out_value | output | 8 | Output register |
| halted | output | 1 | Execution has stopped |

## Verification
Every register update takes one rising edge. A program write is visible on `prog_rdata` after the edge that takes the strobe. Each instruction changes the tape, `out_value` or `halted` at the edge that executes it. `disp_value` and `prog_rdata` follow their address inputs with no clock at all. The bench changes inputs on the falling edge and samples on a later falling edge, after counting the rising edges between the two. Where the exact cycle matters, as for a halt, a clear stall or the end of the program store, the check is placed on a precise edge count. Longer programs are given a generous cycle budget, and then both the halt flag and the results are checked.

// File: rtl/tape_pkg.sv
package tape_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_FWD   = 3'b000,
    OP_BACK  = 3'b001,
    OP_INC   = 3'b010,
    OP_DEC   = 3'b011,
    OP_OPEN  = 3'b100,
    OP_CLOSE = 3'b101,
    OP_EMIT  = 3'b110,
    OP_HALT  = 3'b111
  } op_e;
endpackage

// File: rtl/tape_prog_mem.sv
module tape_prog_mem
  import tape_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [OP_W-1:0] wr_op,
  input  logic [AW-1:0]   fetch_addr,
  output logic [OP_W-1:0] fetch_op,
  input  logic [AW-1:0]   peek_addr,
  output logic [OP_W-1:0] peek_op
);

  logic [OP_W-1:0] mem_q [DEPTH];
  logic [OP_W-1:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    if (wr_en) mem_d[wr_addr] = wr_op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign fetch_op = mem_q[fetch_addr];
  assign peek_op  = mem_q[peek_addr];

  // R2: a strobed opcode lands at the strobed address
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_op));

endmodule

// File: rtl/tape_cells.sv
module tape_cells #(
  parameter int CELLS  = 32,
  parameter int CELL_W = 8,
  parameter int AW     = $clog2(CELLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CELL_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr_a,
  output logic [CELL_W-1:0] rd_data_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [CELL_W-1:0] rd_data_b
);

  logic [CELL_W-1:0] cell_q [CELLS];
  logic [CELL_W-1:0] cell_d [CELLS];

  always_comb begin
    for (int i = 0; i < CELLS; i++) cell_d[i] = cell_q[i];
    if (clr_all) begin
      for (int i = 0; i < CELLS; i++) cell_d[i] = '0;
    end else if (wr_en) begin
      cell_d[wr_addr] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) cell_q[i] <= '0;
    end else if (clr_all || wr_en) begin
      for (int i = 0; i < CELLS; i++) cell_q[i] <= cell_d[i];
    end
  end

  assign rd_data_a = cell_q[rd_addr_a];
  assign rd_data_b = cell_q[rd_addr_b];

  // R10: a clear leaves every readable cell at zero
  a_r10_tape_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (rd_data_a == '0 && rd_data_b == '0));

  // R4: a single cell write lands where addressed
  a_r4_cell_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all) |=> cell_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/tape_step.sv
module tape_step
  import tape_pkg::*;
#(
  parameter int PROG_DEPTH = 64,
  parameter int CELLS      = 32,
  parameter int CELL_W     = 8,
  parameter int PC_W       = $clog2(PROG_DEPTH),
  parameter int DP_W       = $clog2(CELLS),
  parameter int DW         = PC_W + 2
) (
  input  logic [OP_W-1:0]      op,
  input  logic signed [DW-1:0] depth_q,
  input  logic [CELL_W-1:0]    cell_val,
  input  logic [PC_W-1:0]      pc_q,
  input  logic [DP_W-1:0]      dp_q,
  output logic signed [DW-1:0] depth_d,
  output logic [PC_W-1:0]      pc_d,
  output logic                 pc_oor,
  output logic [DP_W-1:0]      dp_d,
  output logic                 cell_wr,
  output logic [CELL_W-1:0]    cell_wdata,
  output logic                 emit,
  output logic                 halt_req
);

  localparam logic signed [DW-1:0] D_ONE   = 1;
  localparam logic [PC_W-1:0]      PC_LAST = PC_W'(PROG_DEPTH - 1);

  logic active;
  logic cell_zero;
  logic go_back;

  assign active    = (depth_q == '0);
  assign cell_zero = (cell_val == '0);

  always_comb begin
    depth_d    = depth_q;
    dp_d       = dp_q;
    cell_wr    = 1'b0;
    cell_wdata = cell_val;
    emit       = 1'b0;
    halt_req   = 1'b0;
    case (op_e'(op))
      OP_OPEN:  if (cell_zero || !active) depth_d = depth_q + D_ONE;
      OP_CLOSE: if (!cell_zero || !active) depth_d = depth_q - D_ONE;
      OP_FWD:   if (active) dp_d = dp_q + DP_W'(1);
      OP_BACK:  if (active) dp_d = dp_q - DP_W'(1);
      OP_INC: begin
        if (active) begin
          cell_wr    = 1'b1;
          cell_wdata = cell_val + CELL_W'(1);
        end
      end
      OP_DEC: begin
        if (active) begin
          cell_wr    = 1'b1;
          cell_wdata = cell_val - CELL_W'(1);
        end
      end
      OP_EMIT:  emit     = active;
      OP_HALT:  halt_req = active;
      default: ;
    endcase
  end

  // direction follows the depth produced in this same cycle
  assign go_back = depth_d[DW-1];

  always_comb begin
    if (go_back) begin
      pc_d   = pc_q - PC_W'(1);
      pc_oor = (pc_q == '0);
    end else begin
      pc_d   = pc_q + PC_W'(1);
      pc_oor = (pc_q == PC_LAST);
    end
  end

endmodule

// File: rtl/tape_interp.sv
module tape_interp
  import tape_pkg::*;
#(
  parameter int PROG_DEPTH = 64,
  parameter int CELLS      = 32,
  parameter int CELL_W     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_mode,
  input  logic        clear,
  input  logic        prog_wr,
  input  logic [5:0]  prog_addr,
  input  logic [2:0]  prog_op,
  output logic [2:0]  prog_rdata,
  input  logic        disp_sel,
  input  logic [4:0]  disp_addr,
  output logic [7:0]  disp_value,
  output logic [7:0]  out_value,
  output logic        halted
);

  localparam int PC_W = $clog2(PROG_DEPTH);
  localparam int DP_W = $clog2(CELLS);
  localparam int DW   = PC_W + 2;

  // state registers
  logic [PC_W-1:0]      pc_q, pc_n;
  logic [DP_W-1:0]      dp_q, dp_n;
  logic signed [DW-1:0] depth_q, depth_n;
  logic [CELL_W-1:0]    out_q, out_n;
  logic                 halted_q, halted_n;

  // datapath nets
  logic [OP_W-1:0]      cur_op;
  logic [OP_W-1:0]      peek_op;
  logic [CELL_W-1:0]    cur_cell;
  logic [CELL_W-1:0]    view_cell;
  logic signed [DW-1:0] st_depth;
  logic [PC_W-1:0]      st_pc;
  logic                 st_oor;
  logic [DP_W-1:0]      st_dp;
  logic                 st_wr;
  logic [CELL_W-1:0]    st_wdata;
  logic                 st_emit;
  logic                 st_halt;
  logic                 run_go;
  logic                 tape_clr;
  logic                 tape_wr;
  logic                 store_wr;

  assign run_go   = run_mode && !halted_q && !clear;
  assign tape_clr = clear || !run_mode;
  assign tape_wr  = run_go && st_wr;
  assign store_wr = !run_mode && prog_wr;

  tape_prog_mem #(.DEPTH(PROG_DEPTH)) u_prog (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (store_wr),
    .wr_addr    (prog_addr),
    .wr_op      (prog_op),
    .fetch_addr (pc_q),
    .fetch_op   (cur_op),
    .peek_addr  (prog_addr),
    .peek_op    (peek_op)
  );

  tape_cells #(.CELLS(CELLS), .CELL_W(CELL_W)) u_tape (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (tape_clr),
    .wr_en     (tape_wr),
    .wr_addr   (dp_q),
    .wr_data   (st_wdata),
    .rd_addr_a (dp_q),
    .rd_data_a (cur_cell),
    .rd_addr_b (disp_addr),
    .rd_data_b (view_cell)
  );

  tape_step #(
    .PROG_DEPTH (PROG_DEPTH),
    .CELLS      (CELLS),
    .CELL_W     (CELL_W)
  ) u_step (
    .op         (cur_op),
    .depth_q    (depth_q),
    .cell_val   (cur_cell),
    .pc_q       (pc_q),
    .dp_q       (dp_q),
    .depth_d    (st_depth),
    .pc_d       (st_pc),
    .pc_oor     (st_oor),
    .dp_d       (st_dp),
    .cell_wr    (st_wr),
    .cell_wdata (st_wdata),
    .emit       (st_emit),
    .halt_req   (st_halt)
  );

  // next-state
  always_comb begin
    pc_n     = pc_q;
    dp_n     = dp_q;
    depth_n  = depth_q;
    halted_n = halted_q;
    if (!run_mode) begin
      pc_n     = '0;
      dp_n     = '0;
      depth_n  = '0;
      halted_n = 1'b0;
    end else if (run_go) begin
      if (st_halt) begin
        halted_n = 1'b1;
      end else begin
        dp_n    = st_dp;
        depth_n = st_depth;
        if (st_oor) halted_n = 1'b1;
        else        pc_n     = st_pc;
      end
    end
  end

  always_comb begin
    out_n = out_q;
    if (clear)                 out_n = '0;
    else if (run_go && st_emit) out_n = cur_cell;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      dp_q     <= '0;
      depth_q  <= '0;
      halted_q <= 1'b0;
    end else begin
      pc_q     <= pc_n;
      dp_q     <= dp_n;
      depth_q  <= depth_n;
      halted_q <= halted_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          out_q <= '0;
    else if (clear || (run_go && st_emit)) out_q <= out_n;
  end

  assign out_value  = out_q;
  assign halted     = halted_q;
  assign prog_rdata = run_mode ? '0 : peek_op;
  assign disp_value = disp_sel ? view_cell : out_q;

  // R10: clear empties the output register
  a_r10_clear_out: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> out_value == '0);

  // R8: a halted run keeps its program counter and stays halted
  a_r8_halt_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && halted_q) |=> ($stable(pc_q) && halted_q));

  // R11: load mode returns the control state to zero
  a_r11_load_resets: assert property (@(posedge clk) disable iff (!rst_n)
    !run_mode |=> (pc_q == '0 && dp_q == '0 && depth_q == '0 && !halted_q));

  // R5: nothing but the depth moves during a bracket search
  a_r5_search_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && !clear && !halted_q && depth_q != '0) |=> ($stable(dp_q) && $stable(out_q)));

  // R10: a clear in run mode stalls the program counter
  a_r10_clear_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && clear) |=> $stable(pc_q));

endmodule

// File: tb/tape_interp_bench.sv
`timescale 1ns/1ps
module tape_interp_bench;

  localparam logic [2:0] C_FWD = 3'b000, C_BACK = 3'b001, C_INC = 3'b010, C_DEC = 3'b011,
                         C_OPEN = 3'b100, C_CLOSE = 3'b101, C_EMIT = 3'b110, C_STOP = 3'b111;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_mode = 1'b0;
  logic       clear = 1'b0;
  logic       prog_wr = 1'b0;
  logic [5:0] prog_addr = '0;
  logic [2:0] prog_op = '0;
  logic [2:0] prog_rdata;
  logic       disp_sel = 1'b0;
  logic [4:0] disp_addr = '0;
  logic [7:0] disp_value;
  logic [7:0] out_value;
  logic       halted;

  int total = 0;
  int bad = 0;
  logic [2:0] pbuf [64];

  always #2.5 clk = ~clk;

  tape_interp u_tape_interp (
    .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .clear(clear),
    .prog_wr(prog_wr), .prog_addr(prog_addr), .prog_op(prog_op),
    .prog_rdata(prog_rdata), .disp_sel(disp_sel), .disp_addr(disp_addr),
    .disp_value(disp_value), .out_value(out_value), .halted(halted)
  );

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic chk_cell(input string req, input int addr, input int exp_v);
    disp_sel  = 1'b1;
    disp_addr = 5'(addr);
    #0.5;
    chk(req, $sformatf("tape[%0d]", addr), int'(disp_value), exp_v);
  endtask

  task automatic fill_stop();
    for (int i = 0; i < 64; i++) pbuf[i] = C_STOP;
  endtask

  task automatic write_all();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      prog_addr = 6'(i);
      prog_op   = pbuf[i];
      prog_wr   = 1'b1;
    end
    @(negedge clk);
    prog_wr = 1'b0;
  endtask

  task automatic run_for(input int n);
    @(negedge clk);
    run_mode = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic leave_run();
    run_mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "halted", int'(halted), 0);
    chk("R1", "out_value", int'(out_value), 0);
    prog_addr = 6'd17;
    #0.5;
    chk("R1", "prog_rdata", int'(prog_rdata), 0);
    chk_cell("R1", 0, 0);
  endtask

  task automatic t_load();
    @(negedge clk);
    prog_addr = 6'd5;  prog_op = C_EMIT; prog_wr = 1'b1;
    @(negedge clk);
    prog_addr = 6'd63; prog_op = C_DEC;
    @(negedge clk);
    prog_wr = 1'b0;
    chk("R2", "readback 63", int'(prog_rdata), int'(C_DEC));
    prog_addr = 6'd5;
    #0.5;
    chk("R2", "readback 5", int'(prog_rdata), int'(C_EMIT));
    @(negedge clk);
    run_mode = 1'b1; prog_op = C_BACK; prog_wr = 1'b1;
    @(negedge clk);
    prog_wr = 1'b0;
    chk("R2", "run-mode readback", int'(prog_rdata), 0);
    leave_run();
    chk("R2", "run-mode write ignored", int'(prog_rdata), int'(C_EMIT));
  endtask

  task automatic t_add();
    fill_stop();
    pbuf[0] = C_INC; pbuf[1] = C_INC; pbuf[2] = C_INC; pbuf[3] = C_FWD;
    pbuf[4] = C_INC; pbuf[5] = C_INC; pbuf[6] = C_BACK; pbuf[7] = C_OPEN;
    pbuf[8] = C_DEC; pbuf[9] = C_FWD; pbuf[10] = C_INC; pbuf[11] = C_BACK;
    pbuf[12] = C_CLOSE; pbuf[13] = C_FWD; pbuf[14] = C_EMIT; pbuf[15] = C_STOP;
    write_all();
    run_for(200);
    chk("R7", "sum output", int'(out_value), 5);
    chk("R8", "halted after sum", int'(halted), 1);
    chk_cell("R3", 1, 5);
    chk_cell("R6", 0, 0);
    leave_run();
    chk("R11", "halted cleared", int'(halted), 0);
    chk("R11", "out kept", int'(out_value), 5);
    chk_cell("R11", 1, 0);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk("R10", "out after load-mode clear", int'(out_value), 0);
  endtask

  task automatic t_wrap();
    fill_stop();
    pbuf[0] = C_DEC; pbuf[1] = C_EMIT; pbuf[2] = C_BACK; pbuf[3] = C_INC;
    write_all();
    run_for(20);
    chk("R4", "cell wrap", int'(out_value), 255);
    chk_cell("R4", 31, 1);
    chk_cell("R4", 0, 255);
    disp_sel = 1'b0;
    #0.5;
    chk("R12", "display of output", int'(disp_value), 255);
    chk_cell("R12", 31, 1);
    leave_run();
  endtask

  task automatic t_skip();
    fill_stop();
    pbuf[0] = C_OPEN; pbuf[1] = C_INC; pbuf[2] = C_STOP; pbuf[3] = C_CLOSE;
    pbuf[4] = C_INC; pbuf[5] = C_EMIT;
    write_all();
    run_for(30);
    chk("R5", "skip over loop", int'(out_value), 1);
    chk("R5", "halt in skipped body ignored", int'(halted), 1);
    leave_run();
    fill_stop();
    pbuf[0] = C_OPEN; pbuf[1] = C_OPEN; pbuf[2] = C_INC; pbuf[3] = C_CLOSE;
    pbuf[4] = C_INC; pbuf[5] = C_CLOSE; pbuf[6] = C_INC; pbuf[6] = C_INC;
    pbuf[7] = C_INC; pbuf[8] = C_EMIT;
    write_all();
    run_for(30);
    chk("R6", "nested forward skip", int'(out_value), 2);
    leave_run();
  endtask

  task automatic t_nested();
    fill_stop();
    pbuf[0] = C_INC; pbuf[1] = C_INC; pbuf[2] = C_OPEN; pbuf[3] = C_FWD;
    pbuf[4] = C_INC; pbuf[5] = C_INC; pbuf[6] = C_OPEN; pbuf[7] = C_FWD;
    pbuf[8] = C_INC; pbuf[9] = C_BACK; pbuf[10] = C_DEC; pbuf[11] = C_CLOSE;
    pbuf[12] = C_BACK; pbuf[13] = C_DEC; pbuf[14] = C_CLOSE; pbuf[15] = C_FWD;
    pbuf[16] = C_FWD; pbuf[17] = C_EMIT;
    write_all();
    run_for(300);
    chk("R6", "nested loops", int'(out_value), 4);
    chk("R7", "nested halted", int'(halted), 1);
    leave_run();
  endtask

  task automatic t_range();
    for (int i = 0; i < 64; i++) pbuf[i] = C_FWD;
    write_all();
    run_for(30);
    chk("R9", "no early halt", int'(halted), 0);
    repeat (40) @(negedge clk);
    chk("R9", "halt past last slot", int'(halted), 1);
    leave_run();
    fill_stop();
    pbuf[0] = C_INC; pbuf[1] = C_CLOSE;
    write_all();
    run_for(20);
    chk("R9", "halt below slot 0", int'(halted), 1);
    chk_cell("R9", 0, 1);
    leave_run();
  endtask

  task automatic t_clear();
    fill_stop();
    for (int i = 0; i < 10; i++) pbuf[i] = C_INC;
    pbuf[10] = C_EMIT;
    write_all();
    run_for(3);
    chk_cell("R3", 0, 3);
    clear = 1'b1;
    @(negedge clk);
    chk_cell("R10", 0, 0);
    @(negedge clk);
    clear = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10", "stall during clear", int'(out_value), 7);
    chk("R8", "halt after clear", int'(halted), 1);
    leave_run();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_add();
    t_wrap();
    t_skip();
    t_nested();
    t_range();
    t_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule